// File: doc/BRIEF.md
# Strobe-Referenced Delay Histogram

This block measures how long after a periodic reference strobe each hit pulse arrives and accumulates those delays into a histogram held in on-chip counters. It generates the reference strobe itself. A phase counter restarts with every strobe, and the phase value in the cycle of a hit's rising edge selects the bin to increment. With the default parameters there are 500 bins of one clock period each, covering the first 500 cycles of each 600-cycle strobe period.

Hits that fall after the histogram window, or before the first strobe has been issued, do not touch any bin. They advance a separate overflow counter instead. Every counter stops at its all-ones value rather than wrapping. A readout port scans the bins without pause, one bin per cycle, and accumulation carries on while it runs.

A clear request zeroes the bins one per cycle and holds a busy flag for the whole sweep. The histogram can then be restarted without a reset.

Top module: `delay_histogram`

## Requirements
- R1: The phase counter is 0 in the first cycle in which `strobe_o` is high. `strobe_o` stays high for STB_W cycles and rises again every PERIOD cycles. The first strobe rises in the second cycle after reset is released.
- R2: A rising edge of `hit_in` sampled while the phase is d, with d < NBINS, increments bin d by one. The phase is the number of cycles since the current strobe rose.
- R3: Only the low-to-high transition of `hit_in` counts. A hit held high for several cycles adds exactly one count.
- R4: A rising edge sampled at phase NBINS or later, or before the first strobe, leaves all bins unchanged and adds one to `ovf_cnt_o`.
- R5: When `rd_vld_o` is high, `rd_bin_o` holds a bin index and `rd_cnt_o` holds that bin's count. The index advances by one each cycle and wraps from NBINS-1 to 0. `rd_vld_o` is high from the first cycle after reset.
- R6: A bin counter and the overflow counter hold at 2^CW-1 instead of wrapping.
- R7: A pulse on `clear_in` while idle raises `busy_o` for exactly NBINS cycles. It zeroes every bin and `ovf_cnt_o`. Hits that arrive while `busy_o` is high are discarded. `clear_in` has no effect while `busy_o` is high.
- R8: If a bin is read out in the same cycle as it is incremented, the readout shows the value before the increment, and the increment is kept.
- R9: During reset and straight after it, all bins and `ovf_cnt_o` are zero, and `busy_o` and `strobe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bin per period |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_in | input | 1 | Pulse whose delay is measured |
| clear_in | input | 1 | Request to zero the histogram |
| strobe_o | output | 1 | Reference strobe |
| busy_o | output | 1 | High while the clear sweep runs |
| rd_vld_o | output | 1 | Readout data valid |
| rd_bin_o | output | $clog2(NBINS) | Bin index being presented |
| rd_cnt_o | output | CW | Count of that bin |
| ovf_cnt_o | output | CW | Count of hits outside the window |

## Verification
The bench builds the block with PERIOD=61, STB_W=3, NBINS=40 and CW=4. With a 4-bit counter, saturation at 15 takes only a few dozen strobe periods. The late window covers phases 40 to 60, so hits at both of its ends can be placed. Because 61 is not a multiple of 40, the scan position drifts against the strobe phase from one period to the next. The bench waits for the period in which the scanner reaches a chosen bin in the same cycle as a hit lands there, and uses it to check the read-during-increment ordering.

// File: rtl/delay_histogram.sv
module delay_histogram #(
  parameter int PERIOD = 600,
  parameter int STB_W  = 5,
  parameter int NBINS  = 500,
  parameter int CW     = 32,
  localparam int BW    = $clog2(NBINS),
  localparam int PW    = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_in,
  input  logic          clear_in,
  output logic          strobe_o,
  output logic          busy_o,
  output logic          rd_vld_o,
  output logic [BW-1:0] rd_bin_o,
  output logic [CW-1:0] rd_cnt_o,
  output logic [CW-1:0] ovf_cnt_o
);
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] PH_WIN  = PW'(NBINS);
  localparam logic [PW-1:0] PH_STB  = PW'(STB_W);
  localparam logic [BW-1:0] BIN_LAST = BW'(NBINS - 1);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [PW-1:0] ph;
  logic          armed, hit_q;
  logic [BW-1:0] rd_ptr, clr_ptr;
  logic [CW-1:0] mem [NBINS];

  wire          rise   = hit_in & ~hit_q;
  wire          in_win = armed && (ph < PH_WIN);
  wire          inc    = rise && in_win && !busy_o;
  wire          late   = rise && !in_win && !busy_o;
  wire [BW-1:0] bin    = ph[BW-1:0];

  assign strobe_o = armed && (ph < PH_STB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_LAST;
      armed <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      ph    <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      armed <= armed | (ph == PH_LAST);
      hit_q <= hit_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBINS; i++) mem[i] <= '0;
    end else if (busy_o) begin
      mem[clr_ptr] <= '0;
    end else if (inc && mem[bin] != CMAX) begin
      mem[bin] <= mem[bin] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      clr_ptr <= '0;
    end else if (busy_o) begin
      if (clr_ptr == BIN_LAST) busy_o <= 1'b0;
      else clr_ptr <= clr_ptr + 1'b1;
    end else if (clear_in) begin
      busy_o  <= 1'b1;
      clr_ptr <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_cnt_o <= '0;
    else if (clear_in && !busy_o) ovf_cnt_o <= '0;
    else if (late && ovf_cnt_o != CMAX) ovf_cnt_o <= ovf_cnt_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      rd_bin_o <= '0;
      rd_cnt_o <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      rd_ptr   <= (rd_ptr == BIN_LAST) ? '0 : rd_ptr + 1'b1;
      rd_bin_o <= rd_ptr;
      rd_cnt_o <= mem[rd_ptr];
      rd_vld_o <= 1'b1;
    end
  end

  p_strobe_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> ph == '0);

  p_ovf_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_cnt_o != $past(ovf_cnt_o)) |-> (ovf_cnt_o == $past(ovf_cnt_o) + 1'b1 || ovf_cnt_o == '0));

  p_rd_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_o |-> rd_bin_o <= BIN_LAST);

  p_rd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld_o && $past(rd_vld_o)) |->
      rd_bin_o == (($past(rd_bin_o) == BIN_LAST) ? '0 : $past(rd_bin_o) + 1'b1));

  p_ovf_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ovf_cnt_o == '0);

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf_cnt_o) == CMAX && !$past(clear_in)) |-> ovf_cnt_o == CMAX);
endmodule

// File: tb/sim_delay_histogram.sv
`timescale 1ns/1ps
module sim_delay_histogram;
  localparam int PER = 61, STW = 3, NB = 40, CW = 4, BW = $clog2(NB);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, hit = 0, clr = 0;
  logic strobe, busy, vld;
  logic [BW-1:0] rbin;
  logic [CW-1:0] rcnt, ovf;
  int total = 0, bad = 0;
  int exp_b [NB];
  int exp_ovf = 0;

  always #2.5 clk = ~clk;

  delay_histogram #(.PERIOD(PER), .STB_W(STW), .NBINS(NB), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .hit_in(hit), .clear_in(clr),
    .strobe_o(strobe), .busy_o(busy), .rd_vld_o(vld),
    .rd_bin_o(rbin), .rd_cnt_o(rcnt), .ovf_cnt_o(ovf));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic sync_strobe();
    bit prev;
    prev = strobe;
    @(negedge clk);
    while (!(strobe && !prev)) begin
      prev = strobe;
      @(negedge clk);
    end
  endtask

  task automatic hit_at(input int d, input int w);
    sync_strobe();
    repeat (d) @(negedge clk);
    hit = 1;
    repeat (w) @(negedge clk);
    hit = 0;
  endtask

  function automatic void bump(input int d);
    if (d < NB) begin
      if (exp_b[d] < CMAX) exp_b[d]++;
    end else if (exp_ovf < CMAX) exp_ovf++;
  endfunction

  task automatic check_all(input string req);
    @(negedge clk);
    while (!(vld && rbin == 0)) @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      check(rbin == BW'(i) && rcnt == CW'(exp_b[i]), req, int'(rcnt), exp_b[i]);
      @(negedge clk);
    end
    check(ovf == CW'(exp_ovf), req, int'(ovf), exp_ovf);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NB; i++) exp_b[i] = 0;
    repeat (3) @(negedge clk);
    check(!strobe && !busy && !vld && ovf == 0, "R9", int'(ovf), 0);
    rst_n = 1; hit = 1;
    @(negedge clk);
    hit = 0;
    check(strobe, "R1 first strobe", int'(strobe), 1);
    exp_ovf = 1;
    check(ovf == 1, "R4 pre-strobe hit", int'(ovf), 1);
    check(vld, "R5 valid after reset", int'(vld), 1);
    check_all("R9 bins zero");
  endtask

  task automatic t_strobe();
    int hi, per;
    sync_strobe();
    hi = 0; per = 0;
    while (strobe) begin hi++; per++; @(negedge clk); end
    while (!strobe) begin per++; @(negedge clk); end
    check(hi == STW, "R1 width", hi, STW);
    check(per == PER, "R1 period", per, PER);
  endtask

  task automatic t_bins();
    for (int k = 0; k < 3; k++) begin hit_at(7, 1); bump(7); end
    hit_at(0, 1); bump(0);
    hit_at(NB - 1, 1); bump(NB - 1);
    check_all("R2");
  endtask

  task automatic t_wide();
    hit_at(20, 4); bump(20);
    check_all("R3");
  endtask

  task automatic t_late();
    hit_at(NB, 1); bump(NB);
    hit_at(PER - 1, 1); bump(PER - 1);
    check_all("R4");
  endtask

  task automatic t_sat();
    for (int k = 0; k < CMAX + 3; k++) begin hit_at(30, 1); bump(30); end
    check_all("R6");
  endtask

  task automatic t_rdwr();
    int old, tries;
    bit done;
    done = 0; tries = 0;
    while (!done && tries < 200) begin
      tries++;
      sync_strobe();
      if ((int'(rbin) + 1) % NB == 0) begin
        repeat (10) @(negedge clk);
        old = exp_b[10];
        hit = 1;
        @(negedge clk);
        hit = 0;
        check(rbin == 10 && rcnt == CW'(old), "R8 old value", int'(rcnt), old);
        bump(10);
        done = 1;
      end
    end
    check(done, "R8 alignment", int'(done), 1);
    check_all("R8 kept");
  endtask

  task automatic t_readout();
    int prevb;
    @(negedge clk);
    prevb = int'(rbin);
    for (int i = 0; i < 2 * NB; i++) begin
      @(negedge clk);
      if (i == 0 || int'(rbin) != (prevb + 1) % NB)
        check(vld && int'(rbin) == (prevb + 1) % NB, "R5 sequence", int'(rbin), (prevb + 1) % NB);
      prevb = int'(rbin);
    end
  endtask

  task automatic t_clear();
    int n;
    clr = 1;
    @(negedge clk);
    clr = 0;
    check(busy, "R7 busy", int'(busy), 1);
    n = 0;
    while (busy && n < 10 * NB) begin
      n++;
      if (n == 5) hit = 1;
      if (n == 6) hit = 0;
      if (n == 8) clr = 1;
      if (n == 9) clr = 0;
      @(negedge clk);
    end
    check(n == NB, "R7 busy length", n, NB);
    check(!busy, "R7 second clear ignored", int'(busy), 0);
    for (int i = 0; i < NB; i++) exp_b[i] = 0;
    exp_ovf = 0;
    check_all("R7 zeroed");
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_strobe();
    t_bins();
    t_wide();
    t_late();
    t_sat();
    t_rdwr();
    t_readout();
    t_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule